// File: doc/BRIEF.md
# Bus I/O Port and Interrupt Responder

This block sits on the peripheral side of a narrow processor bus. There is no address bus. Instead, each bus cycle carries a 5-bit operation code, an 8-bit data byte and a cycle strobe. The responder owns a small bank of readable and writable I/O ports, a write-only timer reload register and a write-only interrupt-control register. It also owns a fixed 16-bit interrupt vector and a pending-request latch.

Port accesses take two bus cycles. In every cycle, the byte on the bus is captured as a candidate port address at the strobe. A port-write code in the next cycle stores the current bus byte into the addressed register. A port-read code in the next cycle drives the addressed port onto the bus. The block responds only if the captured address belongs to it.

Interrupt service also takes two codes. An external event sets the pending request, and the request is presented only while the control register enables it. When the priority chain grants this device, one code makes it drive the low vector byte. A second code makes it drive the high vector byte, and the pending request is then released. A freeze code holds the request latch unchanged for its cycle.

Top module: `rbus_io_irq`

## Requirements
- R1: After reset, the data output enable and the interrupt request output are low, and every port and the timer reload value read zero.
- R2: A strobed cycle with code 0x1A, whose previous strobed cycle carried a port address (PORT_BASE up to PORT_BASE+NUM_PORTS-1), loads the current bus byte into that port. The new value appears on `pio_out` (port k at bits 8k+7:8k) one clock after the strobe.
- R3: During a cycle with code 0x1B, whose previous strobed cycle carried a port address, the block raises `dbus_oe` and drives that port's value on `dbus_out` in the same cycle.
- R4: Code 0x1B never drives the bus when the previous address is the timer address, the interrupt-control address or an address not owned by the block. Apart from 0x1B, only codes 0x0F and 0x13 can ever enable the output.
- R5: Code 0x1A with an address not owned by the block leaves every port and the timer reload value unchanged.
- R6: Code 0x1A with the previous address equal to TIMER_ADDR loads the bus byte into `timer_reload`.
- R7: Code 0x1A with the previous address equal to ICTL_ADDR sets the interrupt enable from bus bit 0. `irq_req` is high exactly when a request is pending and the enable is set, and the pending state survives a disable.
- R8: `irq_event` high at a strobe makes the request pending from the next clock, except in a code 0x10 cycle. Events are sampled only at strobes.
- R9: During code 0x0F with `prio_grant` and `irq_req` both high, the block drives VECTOR[7:0], and the request stays pending.
- R10: During code 0x13 with `prio_grant` and `irq_req` both high, the block drives VECTOR[15:8], and the pending request is cleared one clock after the strobe. The clear takes precedence over a simultaneous event.
- R11: Codes 0x0F and 0x13 do not drive the bus when either the grant or the request is low. A code 0x13 without service does not clear the request.
- R12: A strobed code 0x10 cycle leaves the pending request unchanged, whatever `irq_event` is.
- R13: Only the address captured at the immediately preceding strobe counts. An owned address two strobes back is not used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cyc_stb | input | 1 | One-clock strobe ending each bus cycle |
| code | input | 5 | Operation code of the current bus cycle |
| dbus_in | input | 8 | Data bus byte seen by the block |
| dbus_out | output | 8 | Byte the block drives (zero when not driving) |
| dbus_oe | output | 1 | Data bus drive enable |
| prio_grant | input | 1 | Interrupt priority grant for this device |
| irq_event | input | 1 | Interrupt event, sampled at strobes |
| irq_req | output | 1 | Enabled, pending interrupt request |
| timer_reload | output | 8 | Timer reload register value |
| pio_out | output | 8*NUM_PORTS | Current port values, port k in bits 8k+7:8k |

## Verification
Bus drive results (R3, R4, R9, R10 data, R11) are combinational on the current code and the registered address. The bench reads them 2 ns after the falling edge of the cycle that carries the code, before the rising edge where the strobe lands. Register effects (R2, R5 to R8, R10 clear, R12) take effect at that strobing edge. They are read in an idle cycle that follows, one clock after the strobe. The reset check waits for the two synchronizer stages to release before reading anything.

// File: rtl/rbus_io_pkg.sv
package rbus_io_pkg;
  localparam int DW = 8;
  localparam int CW = 5;

  typedef enum logic [CW-1:0] {
    CMD_VEC_LO  = 5'h0F,
    CMD_FREEZE  = 5'h10,
    CMD_VEC_HI  = 5'h13,
    CMD_PORT_WR = 5'h1A,
    CMD_PORT_RD = 5'h1B
  } bus_cmd_e;
endpackage

// File: rtl/rbus_addr_dec.sv
module rbus_addr_dec #(
  parameter int AW         = 8,
  parameter int PORT_BASE  = 4,
  parameter int NUM_PORTS  = 2,
  parameter int TIMER_ADDR = 6,
  parameter int ICTL_ADDR  = 7,
  localparam int IW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic [AW-1:0] addr,
  output logic          port_hit,
  output logic [IW-1:0] port_idx,
  output logic          timer_hit,
  output logic          ictl_hit
);
  always_comb begin
    port_hit = 1'b0;
    port_idx = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (addr == AW'(PORT_BASE + i)) begin
        port_hit = 1'b1;
        port_idx = IW'(i);
      end
    end
  end

  assign timer_hit = (addr == AW'(TIMER_ADDR));
  assign ictl_hit  = (addr == AW'(ICTL_ADDR));
endmodule

// File: rtl/rbus_port_file.sv
module rbus_port_file #(
  parameter int DW        = 8,
  parameter int NUM_PORTS = 2,
  localparam int IW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IW-1:0]          wr_idx,
  input  logic [DW-1:0]          wr_data,
  input  logic [IW-1:0]          rd_idx,
  output logic [DW-1:0]          rd_data,
  output logic [NUM_PORTS*DW-1:0] ports_flat
);
  logic [DW-1:0] port_q [NUM_PORTS];

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    logic          ld;
    logic [DW-1:0] port_d;

    always_comb begin
      ld     = wr_en && (wr_idx == IW'(g));
      port_d = ld ? wr_data : port_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  port_q[g] <= '0;
      else if (ld) port_q[g] <= port_d;
    end

    assign ports_flat[g*DW +: DW] = port_q[g];
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (rd_idx == IW'(i)) rd_data = port_q[i];
    end
  end
endmodule

// File: rtl/rbus_irq_unit.sv
module rbus_irq_unit
  import rbus_io_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb,
  input  logic [CW-1:0] code,
  input  logic          en_wr,
  input  logic          en_wr_val,
  input  logic          event_in,
  input  logic          grant,
  output logic          req,
  output logic          drive_lo,
  output logic          drive_hi
);
  logic pend_q, pend_d, pend_ce;
  logic en_q, en_d;
  logic inhibit;

  assign req      = pend_q & en_q;
  assign drive_lo = (code == CMD_VEC_LO) && grant && req;
  assign drive_hi = (code == CMD_VEC_HI) && grant && req;
  assign inhibit  = (code == CMD_FREEZE);

  always_comb begin
    pend_ce = stb && !inhibit;
    pend_d  = pend_q;
    if (drive_hi)      pend_d = 1'b0;
    else if (event_in) pend_d = 1'b1;
    en_d = en_wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_ce) pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= 1'b0;
    else if (en_wr) en_q <= en_d;
  end
endmodule

// File: rtl/rbus_io_irq.sv
module rbus_io_irq
  import rbus_io_pkg::*;
#(
  parameter int          PORT_BASE  = 4,
  parameter int          NUM_PORTS  = 2,
  parameter int          TIMER_ADDR = 6,
  parameter int          ICTL_ADDR  = 7,
  parameter logic [15:0] VECTOR     = 16'hA35C,
  localparam int IW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cyc_stb,
  input  logic [4:0]              code,
  input  logic [7:0]              dbus_in,
  output logic [7:0]              dbus_out,
  output logic                    dbus_oe,
  input  logic                    prio_grant,
  input  logic                    irq_event,
  output logic                    irq_req,
  output logic [7:0]              timer_reload,
  output logic [NUM_PORTS*8-1:0]  pio_out
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  // address captured at every strobe
  logic [DW-1:0] addr_q, addr_d;
  always_comb addr_d = dbus_in;
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)     addr_q <= '0;
    else if (cyc_stb) addr_q <= addr_d;
  end

  logic          port_hit, timer_hit, ictl_hit;
  logic [IW-1:0] port_idx;

  rbus_addr_dec #(
    .AW(DW), .PORT_BASE(PORT_BASE), .NUM_PORTS(NUM_PORTS),
    .TIMER_ADDR(TIMER_ADDR), .ICTL_ADDR(ICTL_ADDR)
  ) dec_i (
    .addr(addr_q), .port_hit(port_hit), .port_idx(port_idx),
    .timer_hit(timer_hit), .ictl_hit(ictl_hit)
  );

  logic wr_cyc, rd_cyc;
  assign wr_cyc = cyc_stb && (code == CMD_PORT_WR);
  assign rd_cyc = (code == CMD_PORT_RD);

  logic [DW-1:0] port_rd;
  rbus_port_file #(.DW(DW), .NUM_PORTS(NUM_PORTS)) ports_i (
    .clk(clk), .rst_n(rst_i_n),
    .wr_en(wr_cyc && port_hit), .wr_idx(port_idx), .wr_data(dbus_in),
    .rd_idx(port_idx), .rd_data(port_rd), .ports_flat(pio_out)
  );

  // timer reload register (write only)
  logic [DW-1:0] tmr_q, tmr_d;
  logic          tmr_ce;
  always_comb begin
    tmr_ce = wr_cyc && timer_hit;
    tmr_d  = dbus_in;
  end
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)    tmr_q <= '0;
    else if (tmr_ce) tmr_q <= tmr_d;
  end
  assign timer_reload = tmr_q;

  logic vec_lo, vec_hi;
  rbus_irq_unit irq_i (
    .clk(clk), .rst_n(rst_i_n), .stb(cyc_stb), .code(code),
    .en_wr(wr_cyc && ictl_hit), .en_wr_val(dbus_in[0]),
    .event_in(irq_event), .grant(prio_grant),
    .req(irq_req), .drive_lo(vec_lo), .drive_hi(vec_hi)
  );

  // bus drive
  logic port_drive;
  assign port_drive = rd_cyc && port_hit;

  always_comb begin
    dbus_oe  = port_drive || vec_lo || vec_hi;
    dbus_out = '0;
    if (port_drive)  dbus_out = port_rd;
    else if (vec_lo) dbus_out = VECTOR[7:0];
    else if (vec_hi) dbus_out = VECTOR[15:8];
  end
endmodule

// File: rtl/rbus_io_irq_chk.sv
module rbus_io_irq_chk #(
  parameter int          NUM_PORTS = 2,
  parameter logic [15:0] VECTOR    = 16'hA35C
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cyc_stb,
  input logic [4:0]             code,
  input logic [7:0]             dbus_out,
  input logic                   dbus_oe,
  input logic                   prio_grant,
  input logic                   irq_req,
  input logic [7:0]             timer_reload,
  input logic [NUM_PORTS*8-1:0] pio_out
);
  AST_OE_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    dbus_oe |-> (code == 5'h1B || code == 5'h0F || code == 5'h13)); // R4

  AST_VEC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (dbus_oe && code == 5'h0F) |-> (dbus_out == VECTOR[7:0] && prio_grant && irq_req)); // R9

  AST_VEC_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (dbus_oe && code == 5'h13) |-> (dbus_out == VECTOR[15:8] && prio_grant && irq_req)); // R10

  AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_stb && dbus_oe && code == 5'h13) |=> !irq_req); // R10

  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_stb && code == 5'h10) |=> $stable(irq_req)); // R12

  AST_IDLE_REGS: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_stb |=> ($stable(pio_out) && $stable(timer_reload))); // R2
endmodule

bind rbus_io_irq rbus_io_irq_chk #(.NUM_PORTS(NUM_PORTS), .VECTOR(VECTOR)) chk_i (
  .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .code(code),
  .dbus_out(dbus_out), .dbus_oe(dbus_oe), .prio_grant(prio_grant),
  .irq_req(irq_req), .timer_reload(timer_reload), .pio_out(pio_out)
);

// File: tb/rbus_io_irq_tb_top.sv
`timescale 1ns/1ps
module rbus_io_irq_tb_top;
  localparam logic [15:0] VEC = 16'hA35C;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cyc_stb;
  logic [4:0]  code;
  logic [7:0]  dbus_in;
  logic [7:0]  dbus_out;
  logic        dbus_oe;
  logic        prio_grant;
  logic        irq_event;
  logic        irq_req;
  logic [7:0]  timer_reload;
  logic [15:0] pio_out;

  int checks = 0;
  int errors = 0;
  bit reported = 0;

  always #4 clk = ~clk;

  rbus_io_irq #(.PORT_BASE(4), .NUM_PORTS(2), .TIMER_ADDR(6), .ICTL_ADDR(7), .VECTOR(VEC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .code(code), .dbus_in(dbus_in),
    .dbus_out(dbus_out), .dbus_oe(dbus_oe), .prio_grant(prio_grant),
    .irq_event(irq_event), .irq_req(irq_req), .timer_reload(timer_reload), .pio_out(pio_out)
  );

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
    end
  endtask

  // one strobed bus cycle; returns with combinational outputs settled
  task automatic bus_cyc(input logic [4:0] c, input logic [7:0] d);
    @(negedge clk);
    code = c; dbus_in = d; cyc_stb = 1'b1;
    #2;
  endtask

  // idle clock after a strobe; registered results are readable on return
  task automatic idle();
    @(negedge clk);
    cyc_stb = 1'b0; code = 5'h1C; dbus_in = 8'h00; irq_event = 1'b0;
    #2;
  endtask

  task automatic t_reset();
    check("R1", "oe", {15'd0, dbus_oe}, 16'd0);
    check("R1", "irq_req", {15'd0, irq_req}, 16'd0);
    check("R1", "ports", pio_out, 16'h0000);
    check("R1", "timer", {8'd0, timer_reload}, 16'd0);
  endtask

  task automatic t_port_rw();
    bus_cyc(5'h1C, 8'h04); bus_cyc(5'h1A, 8'h5A); idle();
    check("R2", "port0 after write", pio_out, 16'h005A);
    bus_cyc(5'h1C, 8'h05); bus_cyc(5'h1A, 8'hC3); idle();
    check("R2", "port1 after write", pio_out, 16'hC35A);
    bus_cyc(5'h1C, 8'h04); bus_cyc(5'h1B, 8'h00);
    check("R3", "read port0 oe", {15'd0, dbus_oe}, 16'd1);
    check("R3", "read port0 data", {8'd0, dbus_out}, 16'h005A);
    bus_cyc(5'h1C, 8'h05); bus_cyc(5'h1B, 8'h00);
    check("R3", "read port1 data", {8'd0, dbus_out}, 16'h00C3);
    idle();
  endtask

  task automatic t_prev_only();
    bus_cyc(5'h1C, 8'h05); bus_cyc(5'h1C, 8'h99); bus_cyc(5'h1B, 8'h00);
    check("R13", "stale address read oe", {15'd0, dbus_oe}, 16'd0);
    bus_cyc(5'h1C, 8'h04); bus_cyc(5'h1C, 8'h99); bus_cyc(5'h1A, 8'h11); idle();
    check("R13", "stale address write", pio_out, 16'hC35A);
  endtask

  task automatic t_no_readback();
    bus_cyc(5'h1C, 8'h06); bus_cyc(5'h1B, 8'h00);
    check("R4", "timer read oe", {15'd0, dbus_oe}, 16'd0);
    bus_cyc(5'h1C, 8'h07); bus_cyc(5'h1B, 8'h00);
    check("R4", "ictl read oe", {15'd0, dbus_oe}, 16'd0);
    bus_cyc(5'h1C, 8'h40); bus_cyc(5'h1B, 8'h00);
    check("R4", "foreign read oe", {15'd0, dbus_oe}, 16'd0);
    idle();
  endtask

  task automatic t_foreign_write();
    bus_cyc(5'h1C, 8'h40); bus_cyc(5'h1A, 8'hFF); idle();
    check("R5", "ports after foreign write", pio_out, 16'hC35A);
    check("R5", "timer after foreign write", {8'd0, timer_reload}, 16'd0);
  endtask

  task automatic t_timer();
    bus_cyc(5'h1C, 8'h06); bus_cyc(5'h1A, 8'h7E); idle();
    check("R6", "timer load", {8'd0, timer_reload}, 16'h007E);
    check("R6", "ports untouched", pio_out, 16'hC35A);
  endtask

  task automatic t_irq();
    prio_grant = 1'b0;
    irq_event = 1'b1; bus_cyc(5'h1C, 8'h00); idle();
    check("R7", "req while disabled", {15'd0, irq_req}, 16'd0);
    bus_cyc(5'h1C, 8'h07); bus_cyc(5'h1A, 8'h01); idle();
    check("R8", "req after enable", {15'd0, irq_req}, 16'd1);
    bus_cyc(5'h0F, 8'h00);
    check("R11", "vec lo without grant", {15'd0, dbus_oe}, 16'd0);
    bus_cyc(5'h13, 8'h00);
    check("R11", "vec hi without grant", {15'd0, dbus_oe}, 16'd0);
    idle();
    check("R11", "req kept without grant", {15'd0, irq_req}, 16'd1);
    prio_grant = 1'b1;
    bus_cyc(5'h0F, 8'h00);
    check("R9", "vec lo data", {7'd0, dbus_oe, dbus_out}, {8'h01, VEC[7:0]});
    idle();
    check("R9", "req kept after lo", {15'd0, irq_req}, 16'd1);
    irq_event = 1'b1; bus_cyc(5'h13, 8'h00);
    check("R10", "vec hi data", {7'd0, dbus_oe, dbus_out}, {8'h01, VEC[15:8]});
    idle();
    check("R10", "req cleared after hi", {15'd0, irq_req}, 16'd0);
    bus_cyc(5'h0F, 8'h00);
    check("R11", "vec lo without req", {15'd0, dbus_oe}, 16'd0);
    idle();
  endtask

  task automatic t_freeze_and_disable();
    irq_event = 1'b1; bus_cyc(5'h10, 8'h00); idle();
    check("R12", "freeze blocks event", {15'd0, irq_req}, 16'd0);
    irq_event = 1'b1; bus_cyc(5'h1C, 8'h00); idle();
    check("R8", "event sets req", {15'd0, irq_req}, 16'd1);
    bus_cyc(5'h10, 8'h00); idle();
    check("R12", "freeze holds pending", {15'd0, irq_req}, 16'd1);
    bus_cyc(5'h1C, 8'h07); bus_cyc(5'h1A, 8'hFE); idle();
    check("R7", "req after disable", {15'd0, irq_req}, 16'd0);
    bus_cyc(5'h1C, 8'h07); bus_cyc(5'h1A, 8'h01); idle();
    check("R7", "pending survives disable", {15'd0, irq_req}, 16'd1);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    rst_n = 1'b0; cyc_stb = 1'b0; code = 5'h1C; dbus_in = 8'h00;
    prio_grant = 1'b0; irq_event = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) idle();
    t_reset();
    t_port_rw();
    t_prev_only();
    t_no_readback();
    t_foreign_write();
    t_timer();
    t_irq();
    t_freeze_and_disable();
    report();
    $finish;
  end
endmodule